// File: doc/BRIEF.md
# Pixel Format Decoder with Bitwise Masking

This block sits at the front of a colour lookup path. Each clock it takes one pixel as three 8-bit channel streams (red, green, blue), ANDs every channel with a shared programmable 8-bit mask, and then turns the masked pixel into three 8-bit table addresses, one for each of the red, green and blue lookup tables. A 4-bit format code picks how the address bits are taken from the pixel. Three pseudo-colour formats copy one channel to all three addresses. Two 12-bit true-colour packings each build three 4-bit fields. One 24-bit true-colour format passes each channel to its own table.

Up to four devices of this kind can share one pixel bus. Each device is given a fixed palette number, and a per-pixel palette-select input chooses which device is active. A device whose number does not match outputs zero addresses and raises no enable line. The matching device drives a one-hot enable for the chosen palette. The path has two register stages. Blank and sync travel through the same stages, so they arrive aligned with the addresses.

Top module: `pixel_fmt_decoder`

## Requirements
- R1: While rst_ni is low, every output (the three addresses, pal_en_o, blank_o, sync_o) is zero.
- R2: Every channel is ANDed bit by bit with mask_i before decoding. A mask bit of 0 forces that bit of every channel to 0. A mask of 8'h00 in format 111x therefore gives all-zero addresses.
- R3: In a pseudo-colour format, the three addresses are equal. The source is the masked red channel for mode_i[3:2]=2'b00, green for 2'b01 and blue for 2'b10, and mode_i[1:0] has no effect.
- R4: In format 4'b1100, the red address is {R[7:4],4'h0}, the green address is {G[7:4],4'h0} and the blue address is {B[7:4],4'h0}.
- R5: In format 4'b1101, the red address is {R[6:3],4'h0}, the green address is {R[1:0],G[6:5],4'h0} and the blue address is {G[3:0],4'h0}. The blue channel and R[7], R[2], G[7], G[4] have no effect.
- R6: In formats 4'b1110 and 4'b1111, each address equals its own masked channel.
- R7: When pal_sel_i differs from pal_id_i, the three addresses and pal_en_o are zero for that pixel.
- R8: When pal_sel_i equals pal_id_i, pal_en_o has exactly one bit set, at position pal_sel_i.
- R9: The addresses, pal_en_o, blank_o and sync_o for a pixel appear two rising edges after the pixel is sampled. blank_o and sync_o are blank_i and sync_i delayed by those same two edges, whether or not the palette matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| red_i | input | 8 | Red pixel channel |
| grn_i | input | 8 | Green pixel channel |
| blu_i | input | 8 | Blue pixel channel |
| mask_i | input | 8 | Bit mask ANDed into each channel |
| mode_i | input | 4 | Pixel format code |
| pal_sel_i | input | 2 | Per-pixel palette select |
| pal_id_i | input | 2 | Palette number owned by this device |
| blank_i | input | 1 | Blank marker of the pixel |
| sync_i | input | 1 | Sync marker of the pixel |
| red_idx_o | output | 8 | Red table address |
| grn_idx_o | output | 8 | Green table address |
| blu_idx_o | output | 8 | Blue table address |
| pal_en_o | output | 4 | One-hot enable of the selected palette |
| blank_o | output | 1 | Blank, aligned with the addresses |
| sync_o | output | 1 | Sync, aligned with the addresses |

## Verification
The assertions assume that mask_i, mode_i, pal_sel_i and pal_id_i are sampled with each pixel and may change on any cycle. They also assume that two post-reset edges have passed before any output is compared with delayed inputs. The stimulus keeps inputs stable across each rising edge by changing them only on falling edges. It changes the format, mask and palette-select fields from pixel to pixel, so the checks cover per-pixel switching of all three, not only static settings. Directed pixels drive the scattered 12-bit packing, an all-zero mask and a palette miss with blank and sync held high.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned NIB_W  = CH_W / 2;
  localparam int unsigned MODE_W = 4;

  typedef logic [CH_W-1:0] chan_t;

  typedef struct packed {
    chan_t r;
    chan_t g;
    chan_t b;
  } rgb_t;

  typedef enum logic [1:0] {
    FMT_PSEUDO,
    FMT_T12_HI,
    FMT_T12_SCAT,
    FMT_T24
  } fmt_kind_e;

  function automatic fmt_kind_e fmt_classify(input logic [MODE_W-1:0] m);
    if (m[3:2] != 2'b11) return FMT_PSEUDO;
    if (m[1]) return FMT_T24;
    if (m[0]) return FMT_T12_SCAT;
    return FMT_T12_HI;
  endfunction
endpackage

// File: rtl/pfd_mask_stage.sv
module pfd_mask_stage
  import pfd_pkg::*;
#(
  parameter int unsigned PAL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rgb_t              pix_i,
  input  chan_t             mask_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PAL_W-1:0]  pal_sel_i,
  input  logic [PAL_W-1:0]  pal_id_i,
  input  logic              blank_i,
  input  logic              sync_i,
  output rgb_t              pix_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              hit_o,
  output logic [PAL_W-1:0]  pal_sel_o,
  output logic              blank_o,
  output logic              sync_o
);
  rgb_t masked;

  always_comb begin
    masked.r = pix_i.r & mask_i;
    masked.g = pix_i.g & mask_i;
    masked.b = pix_i.b & mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o     <= '0;
      mode_o    <= '0;
      hit_o     <= 1'b0;
      pal_sel_o <= '0;
      blank_o   <= 1'b0;
      sync_o    <= 1'b0;
    end else begin
      pix_o     <= masked;
      mode_o    <= mode_i;
      hit_o     <= (pal_sel_i == pal_id_i);
      pal_sel_o <= pal_sel_i;
      blank_o   <= blank_i;
      sync_o    <= sync_i;
    end
  end

  // masked bits never survive into stage one
  assert_mask_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pix_o.r | pix_o.g | pix_o.b) & ~$past(mask_i)) == '0);
endmodule

// File: rtl/pfd_extract.sv
module pfd_extract
  import pfd_pkg::*;
(
  input  rgb_t              pix_i,
  input  logic [MODE_W-1:0] mode_i,
  output rgb_t              idx_o
);
  fmt_kind_e kind;
  chan_t     pseudo_src;

  always_comb begin
    kind = fmt_classify(mode_i);
    unique case (mode_i[3:2])
      2'b00:   pseudo_src = pix_i.r;
      2'b01:   pseudo_src = pix_i.g;
      default: pseudo_src = pix_i.b;
    endcase
  end

  always_comb begin
    idx_o = '0;
    unique case (kind)
      FMT_PSEUDO: begin
        idx_o.r = pseudo_src;
        idx_o.g = pseudo_src;
        idx_o.b = pseudo_src;
      end
      FMT_T12_HI: begin
        idx_o.r = {pix_i.r[CH_W-1 -: NIB_W], {NIB_W{1'b0}}};
        idx_o.g = {pix_i.g[CH_W-1 -: NIB_W], {NIB_W{1'b0}}};
        idx_o.b = {pix_i.b[CH_W-1 -: NIB_W], {NIB_W{1'b0}}};
      end
      FMT_T12_SCAT: begin
        // scattered packing: fields straddle red and green
        idx_o.r = {pix_i.r[6:3], {NIB_W{1'b0}}};
        idx_o.g = {pix_i.r[1:0], pix_i.g[6:5], {NIB_W{1'b0}}};
        idx_o.b = {pix_i.g[3:0], {NIB_W{1'b0}}};
      end
      default: idx_o = pix_i;
    endcase
  end

  always_comb begin
    if (kind == FMT_PSEUDO) begin
      assert_pseudo_equal_R3: assert (idx_o.r == idx_o.g && idx_o.g == idx_o.b);
    end
    if (kind == FMT_T12_HI || kind == FMT_T12_SCAT) begin
      assert_low_nibble_zero_R4: assert ((idx_o.r[NIB_W-1:0] | idx_o.g[NIB_W-1:0]
                                          | idx_o.b[NIB_W-1:0]) == '0);
    end
  end
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_pkg::*;
#(
  parameter int unsigned NUM_PAL = 4,
  localparam int unsigned PAL_W  = $clog2(NUM_PAL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  rgb_t               idx_i,
  input  logic               hit_i,
  input  logic [PAL_W-1:0]   pal_sel_i,
  input  logic               blank_i,
  input  logic               sync_i,
  output rgb_t               idx_o,
  output logic [NUM_PAL-1:0] pal_en_o,
  output logic               blank_o,
  output logic               sync_o
);
  logic [NUM_PAL-1:0] pal_en_d;

  for (genvar p = 0; p < NUM_PAL; p++) begin : g_pal_en
    assign pal_en_d[p] = hit_i && (pal_sel_i == PAL_W'(p));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o    <= '0;
      pal_en_o <= '0;
      blank_o  <= 1'b0;
      sync_o   <= 1'b0;
    end else begin
      idx_o    <= hit_i ? idx_i : '0;
      pal_en_o <= pal_en_d;
      blank_o  <= blank_i;
      sync_o   <= sync_i;
    end
  end

  assert_pal_onehot0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pal_en_o));
endmodule

// File: rtl/pixel_fmt_decoder.sv
module pixel_fmt_decoder
  import pfd_pkg::*;
#(
  parameter int unsigned NUM_PAL = 4,
  localparam int unsigned PAL_W  = $clog2(NUM_PAL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CH_W-1:0]    red_i,
  input  logic [CH_W-1:0]    grn_i,
  input  logic [CH_W-1:0]    blu_i,
  input  logic [CH_W-1:0]    mask_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [PAL_W-1:0]   pal_sel_i,
  input  logic [PAL_W-1:0]   pal_id_i,
  input  logic               blank_i,
  input  logic               sync_i,
  output logic [CH_W-1:0]    red_idx_o,
  output logic [CH_W-1:0]    grn_idx_o,
  output logic [CH_W-1:0]    blu_idx_o,
  output logic [NUM_PAL-1:0] pal_en_o,
  output logic               blank_o,
  output logic               sync_o
);
  rgb_t              pix_in, pix_s1, idx_s1, idx_s2;
  logic [MODE_W-1:0] mode_s1;
  logic              hit_s1, blank_s1, sync_s1;
  logic [PAL_W-1:0]  sel_s1;

  assign pix_in = '{r: red_i, g: grn_i, b: blu_i};

  pfd_mask_stage #(.PAL_W(PAL_W)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_i     (pix_in),
    .mask_i    (mask_i),
    .mode_i    (mode_i),
    .pal_sel_i (pal_sel_i),
    .pal_id_i  (pal_id_i),
    .blank_i   (blank_i),
    .sync_i    (sync_i),
    .pix_o     (pix_s1),
    .mode_o    (mode_s1),
    .hit_o     (hit_s1),
    .pal_sel_o (sel_s1),
    .blank_o   (blank_s1),
    .sync_o    (sync_s1)
  );

  pfd_extract u_extract (
    .pix_i  (pix_s1),
    .mode_i (mode_s1),
    .idx_o  (idx_s1)
  );

  pfd_out_stage #(.NUM_PAL(NUM_PAL)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx_s1),
    .hit_i     (hit_s1),
    .pal_sel_i (sel_s1),
    .blank_i   (blank_s1),
    .sync_i    (sync_s1),
    .idx_o     (idx_s2),
    .pal_en_o  (pal_en_o),
    .blank_o   (blank_o),
    .sync_o    (sync_o)
  );

  assign red_idx_o = idx_s2.r;
  assign grn_idx_o = idx_s2.g;
  assign blu_idx_o = idx_s2.b;

  // edges seen since reset, saturating; gates the two-deep $past checks
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  assert_ctrl_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (blank_o == $past(blank_i, 2) && sync_o == $past(sync_i, 2)));

  assert_miss_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(pal_sel_i, 2) != $past(pal_id_i, 2))
      |-> (idx_s2 == '0 && pal_en_o == '0));

  assert_hit_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(pal_sel_i, 2) == $past(pal_id_i, 2))
      |-> (pal_en_o == (NUM_PAL'(1) << $past(pal_sel_i, 2))));
endmodule

// File: tb/pixel_fmt_decoder_bench.sv
module pixel_fmt_decoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] red_i = '0, grn_i = '0, blu_i = '0, mask_i = '0;
  logic [3:0] mode_i = '0;
  logic [1:0] pal_sel_i = '0, pal_id_i = '0;
  logic       blank_i = 1'b0, sync_i = 1'b0;
  logic [7:0] red_idx_o, grn_idx_o, blu_idx_o;
  logic [3:0] pal_en_o;
  logic       blank_o, sync_o;

  always #4 clk_i = ~clk_i;

  pixel_fmt_decoder u_pixel_fmt_decoder (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] r, g, b;
    logic [3:0] en;
    logic       bl, sy;
    int         tag;
    bit         valid;
  } exp_t;

  exp_t e1, e2;

  function automatic string tag_name(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R?";
    endcase
  endfunction

  function automatic exp_t model(logic [7:0] r, g, b, m, logic [3:0] md,
                                 logic [1:0] sel, id, logic bl, sy);
    exp_t e;
    logic [7:0] mr, mg, mb;
    mr = r & m; mg = g & m; mb = b & m;
    e.bl = bl; e.sy = sy; e.valid = 1;
    if (md[3:2] == 2'b00)      begin e.r = mr; e.g = mr; e.b = mr; e.tag = 3; end
    else if (md[3:2] == 2'b01) begin e.r = mg; e.g = mg; e.b = mg; e.tag = 3; end
    else if (md[3:2] == 2'b10) begin e.r = mb; e.g = mb; e.b = mb; e.tag = 3; end
    else if (md == 4'b1100) begin
      e.r = {mr[7:4], 4'h0}; e.g = {mg[7:4], 4'h0}; e.b = {mb[7:4], 4'h0}; e.tag = 4;
    end else if (md == 4'b1101) begin
      e.r = {mr[6:3], 4'h0}; e.g = {mr[1:0], mg[6:5], 4'h0}; e.b = {mg[3:0], 4'h0}; e.tag = 5;
    end else begin e.r = mr; e.g = mg; e.b = mb; e.tag = 6; end
    if (m != 8'hFF) e.tag = 2;
    if (sel != id) begin
      e.r = '0; e.g = '0; e.b = '0; e.en = '0; e.tag = 7;
    end else e.en = 4'b0001 << sel;
    return e;
  endfunction

  task automatic check_out();
    if (!e2.valid) return;
    checks++;
    if ({red_idx_o, grn_idx_o, blu_idx_o} !== {e2.r, e2.g, e2.b}) begin
      failures++;
      $display("FAIL %s idx act=%h/%h/%h exp=%h/%h/%h", tag_name(e2.tag),
               red_idx_o, grn_idx_o, blu_idx_o, e2.r, e2.g, e2.b);
    end
    checks++;
    if (pal_en_o !== e2.en) begin
      failures++;
      $display("FAIL R8 pal_en act=%b exp=%b", pal_en_o, e2.en);
    end
    checks++;
    if ({blank_o, sync_o} !== {e2.bl, e2.sy}) begin
      failures++;
      $display("FAIL R9 blank/sync act=%b%b exp=%b%b", blank_o, sync_o, e2.bl, e2.sy);
    end
  endtask

  task automatic pixel(logic [7:0] r, g, b, m, logic [3:0] md,
                       logic [1:0] sel, id, logic bl, sy);
    @(negedge clk_i);
    check_out();
    e2 = e1;
    red_i = r; grn_i = g; blu_i = b; mask_i = m; mode_i = md;
    pal_sel_i = sel; pal_id_i = id; blank_i = bl; sync_i = sy;
    e1 = model(r, g, b, m, md, sel, id, bl, sy);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    e1.valid = 0; e2.valid = 0;
    red_i = 8'hFF; grn_i = 8'hFF; blu_i = 8'hFF; mask_i = 8'hFF; mode_i = 4'hE;
    blank_i = 1'b1; sync_i = 1'b1;
    repeat (3) @(negedge clk_i);
    checks++;
    if ({red_idx_o, grn_idx_o, blu_idx_o, pal_en_o, blank_o, sync_o} !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs act=%h/%h/%h/%b/%b%b exp=0", red_idx_o, grn_idx_o,
               blu_idx_o, pal_en_o, blank_o, sync_o);
    end
    red_i = '0; grn_i = '0; blu_i = '0; blank_i = 0; sync_i = 0;
    rst_ni = 1'b1;

    // R5: scattered packing; blue and unused bits must not matter
    pixel(8'hB6, 8'h5A, 8'hFF, 8'hFF, 4'b1101, 2'd1, 2'd1, 0, 0);
    pixel(8'h84, 8'h90, 8'h00, 8'hFF, 4'b1101, 2'd1, 2'd1, 0, 1);
    // R4 hi-nibble packing
    pixel(8'h3C, 8'hA5, 8'h7E, 8'hFF, 4'b1100, 2'd0, 2'd0, 1, 0);
    // R3 each pseudo source, low mode bits varied
    pixel(8'h11, 8'h22, 8'h33, 8'hFF, 4'b0011, 2'd2, 2'd2, 0, 0);
    pixel(8'h11, 8'h22, 8'h33, 8'hFF, 4'b0110, 2'd2, 2'd2, 0, 0);
    pixel(8'h11, 8'h22, 8'h33, 8'hFF, 4'b1001, 2'd2, 2'd2, 0, 0);
    // R6 both true-colour codes
    pixel(8'hDE, 8'hAD, 8'hBE, 8'hFF, 4'b1110, 2'd3, 2'd3, 0, 0);
    pixel(8'hDE, 8'hAD, 8'hBE, 8'hFF, 4'b1111, 2'd3, 2'd3, 0, 0);
    // R2 zero and partial masks
    pixel(8'hFF, 8'hFF, 8'hFF, 8'h00, 4'b1110, 2'd0, 2'd0, 0, 0);
    pixel(8'hFF, 8'hF0, 8'h0F, 8'h5A, 4'b1111, 2'd0, 2'd0, 0, 0);
    // R7 miss with blank/sync still forwarded (R9)
    pixel(8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'b1110, 2'd2, 2'd1, 1, 1);
    pixel(8'h12, 8'h34, 8'h56, 8'hFF, 4'b0000, 2'd0, 2'd3, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] m;
      logic [1:0] id, sel;
      m   = ($urandom % 2) ? 8'hFF : 8'($urandom);
      id  = 2'($urandom);
      sel = ($urandom % 4 == 0) ? 2'($urandom) : id;
      pixel(8'($urandom), 8'($urandom), 8'($urandom), m, 4'($urandom),
            sel, id, 1'($urandom), 1'($urandom));
    end
    pixel('0, '0, '0, 8'hFF, 4'b0000, 2'd0, 2'd0, 0, 0);
    pixel('0, '0, '0, 8'hFF, 4'b0000, 2'd0, 2'd0, 0, 0);
    pixel('0, '0, '0, 8'hFF, 4'b0000, 2'd0, 2'd0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule